// File: doc/BRIEF.md
# Byte-Wide Data EEPROM Control Registers

This block is the register front end of a small on-chip data EEPROM. Software reaches four byte-wide registers over a simple bus: an address register, a data register, a control/status register and a key register that can only be written. Setting a bit in the control register starts an array read, which copies the addressed byte into the data register. A write to the array is timed: it takes a fixed number of cycles, and during that time the control register shows a busy flag.

Stray or runaway writes are blocked by two guards. Before the write-start bit is set, the key register must receive two fixed bytes in consecutive bus writes, and a separate enable bit must already be set. When a write ends, a sticky flag records how it ended, either completed or aborted, and software clears that flag by writing 0 to it. The array is a register array inside the block. A parameterised down-counter stands in for the programming time of the cells.

Top module: `ee_ctl_regs`

## Requirements
- R1: `bus_sel` selects the register: 0 is the address register (8 bits, read/write), 1 is the data register (read/write), 2 is control/status, and 3 is the key register, which always reads 0. The control bits are: bit 0 read-start, bit 1 write-start/busy, bit 2 write enable, bit 3 error flag, bit 4 done flag. Bits 7..5 read 0. After reset every register and every array byte is 0.
- R2: A control write with bit 1 set starts an array write only if the two bus writes just before it were 0x55 and then 0xAA to the key register. Any other bus write, including a key write out of order, drops the unlock progress.
- R3: The write-enable bit must already hold 1 before the control write that sets write-start. Otherwise no array write starts. That same control write still loads the new enable value.
- R4: An accepted write captures the current address and data. Control bit 1 then reads 1 for exactly WRITE_CYCLES cycles, counted from the accepting edge. On the last of those cycles the array byte is updated, bit 1 clears and the done flag is set.
- R5: A control write with bit 0 set loads the data register with the array byte at the current address. That data register load takes effect at the same edge as the control write. Bit 0 reads 1 for the following cycle only, unless it is written again.
- R6: The done and error flags keep their value until software writes 0 to them in a control write. Writing 1 leaves them unchanged.
- R7: If `wr_abort` is high while a write is in progress, the write ends at that edge: busy clears, the error flag sets and the array byte keeps its old value. When no write is in progress, `wr_abort` has no effect.
- R8: If the hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R9: Only address bits 5..0 select one of the 64 array bytes. Bits 7..6 are ignored for array access.
- R10: `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from the selected register |
| wr_abort | input | 1 | Aborts a write that is in progress |

## Verification
Two pairs of events can fall on the same edge. The first pair is the final count of a write and a control write by software that clears the done flag. The bench provokes this by issuing a control write exactly WRITE_CYCLES cycles after the write-start edge, with bit 4 at 0, and it expects the done flag to read 1 afterwards. The second pair is the final count of a write and an assertion of `wr_abort`. The bench judges that the abort wins, so the error flag sets and the array byte keeps its old value. The bench checks both outcomes against a behavioural model that it updates once per clock.

// File: rtl/ee_ctl_regs.sv
module ee_ctl_regs #(
  parameter int AW           = 6,
  parameter int WRITE_CYCLES = 12,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wr_abort
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [1:0] {U_IDLE, U_KEYA, U_ARMED} ust_t;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    addr_q, data_q, wd_q;
  logic [AW-1:0] wa_q;
  logic          rd_q, wren_q, err_q, done_q, busy_q;
  logic [CW-1:0] cnt_q;
  ust_t          ust_q;

  wire wr_addr = bus_we && bus_sel == 2'd0;
  wire wr_data = bus_we && bus_sel == 2'd1;
  wire wr_ctl  = bus_we && bus_sel == 2'd2;
  wire wr_key  = bus_we && bus_sel == 2'd3;

  wire [AW-1:0] ix = addr_q[AW-1:0];

  wire start  = wr_ctl && bus_wdata[1] && ust_q == U_ARMED && wren_q && !busy_q;
  wire kill   = busy_q && wr_abort;
  wire finish = busy_q && !wr_abort && cnt_q == CW'(1);

  wire [7:0] ctl_view = {3'b000, done_q, err_q, wren_q, busy_q, rd_q};

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_re)
      case (bus_sel)
        2'd0:    bus_rdata = addr_q;
        2'd1:    bus_rdata = data_q;
        2'd2:    bus_rdata = ctl_view;
        default: bus_rdata = 8'h00;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ust_q <= U_IDLE;
    else if (bus_we) begin
      if (wr_key && bus_wdata == KEY_A && ust_q == U_IDLE)
        ust_q <= U_KEYA;
      else if (wr_key && bus_wdata == KEY_B && ust_q == U_KEYA)
        ust_q <= U_ARMED;
      else
        ust_q <= U_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wren_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= bus_wdata;
      if (wr_ctl) wren_q <= bus_wdata[2];
      rd_q <= wr_ctl && bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (wr_data)
      data_q <= bus_wdata;
    else if (wr_ctl && bus_wdata[0])
      data_q <= mem[ix];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= kill   || (err_q  && !(wr_ctl && !bus_wdata[3]));
      done_q <= finish || (done_q && !(wr_ctl && !bus_wdata[4]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WRITE_CYCLES);
      wa_q   <= ix;
      wd_q   <= data_q;
    end else if (kill || finish) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (finish) begin
      mem[wa_q] <= wd_q;
    end
  end
endmodule

module ee_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       wr_abort,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       rd,
  input logic       wren,
  input logic [1:0] ust
);
  // R2 R3
  start_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ust) == 2'd2 && $past(wren) && $past(bus_we) && $past(bus_sel) == 2'd2);

  // R4
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || err);

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !(bus_we && bus_sel == 2'd2 && bus_wdata[0]) |=> !rd);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(bus_we && bus_sel == 2'd2 && !bus_wdata[4]) |=> done);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(bus_we && bus_sel == 2'd2 && !bus_wdata[3]) |=> err);

  // R7
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_abort |=> !busy && err);
endmodule

bind ee_ctl_regs ee_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .wr_abort(wr_abort), .busy(busy_q), .done(done_q),
  .err(err_q), .rd(rd_q), .wren(wren_q), .ust(ust_q)
);

// File: tb/sim_ee_ctl_regs.sv
`timescale 1ns/1ps
module sim_ee_ctl_regs;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0, wr_abort = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  always #2.5 clk = ~clk;

  ee_ctl_regs #(.WRITE_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_abort(wr_abort)
  );

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  logic [7:0] m_mem [64];
  logic [7:0] m_addr, m_data, m_wd;
  logic [5:0] m_wa;
  logic m_rd, m_wren, m_err, m_done, m_busy;
  int m_cnt, m_st;

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    m_addr = 0; m_data = 0; m_wd = 0; m_wa = 0;
    m_rd = 0; m_wren = 0; m_err = 0; m_done = 0; m_busy = 0; m_cnt = 0; m_st = 0;
  endtask

  task automatic model_edge(input logic we, input logic [1:0] s, input logic [7:0] d, input logic ab);
    logic o_busy, o_wren;
    logic [7:0] o_data, o_addr;
    int o_st;
    o_busy = m_busy; o_wren = m_wren; o_st = m_st; o_data = m_data; o_addr = m_addr;
    m_rd = 0;
    if (we) begin
      case (s)
        2'd0: m_addr = d;
        2'd1: m_data = d;
        2'd2: begin
          m_rd = d[0];
          if (d[0]) m_data = m_mem[o_addr[5:0]];
          m_wren = d[2];
          m_err = m_err & d[3];
          m_done = m_done & d[4];
        end
        default: ;
      endcase
    end
    if (o_busy && ab) begin
      m_busy = 0; m_err = 1;
    end else if (o_busy) begin
      if (m_cnt == 1) begin
        m_mem[m_wa] = m_wd; m_busy = 0; m_done = 1;
      end else m_cnt--;
    end
    if (we && s == 2'd2 && d[1] && o_st == 2 && o_wren && !o_busy) begin
      m_busy = 1; m_cnt = W; m_wa = o_addr[5:0]; m_wd = o_data;
    end
    if (we) begin
      if (s == 2'd3 && d == 8'h55 && o_st == 0) m_st = 1;
      else if (s == 2'd3 && d == 8'hAA && o_st == 1) m_st = 2;
      else m_st = 0;
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic re, input logic [1:0] s);
    if (!re) return 8'h00;
    case (s)
      2'd0: return m_addr;
      2'd1: return m_data;
      2'd2: return {3'b000, m_done, m_err, m_wren, m_busy, m_rd};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic we, input logic re, input logic [1:0] s, input logic [7:0] d, input logic ab);
    logic [7:0] e;
    bus_we = we; bus_re = re; bus_sel = s; bus_wdata = d; wr_abort = ab;
    @(posedge clk);
    model_edge(we, s, d, ab);
    @(negedge clk);
    e = expect_rd(re, s);
    vectors++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s: sel=%0d re=%0b rdata=%h expected %h", cur_req, s, re, bus_rdata, e);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d); step(1, 0, s, d, 0); endtask
  task automatic rdr(input logic [1:0] s); step(0, 1, s, 8'h00, 0); endtask
  task automatic wr_rd(input logic [1:0] s, input logic [7:0] d); step(1, 1, s, d, 0); endtask

  task automatic unlock_start();
    wr(3, 8'h55); wr(3, 8'hAA); wr(2, 8'h06);
  endtask

  task automatic poll(input int n);
    for (int i = 0; i < n; i++) rdr(2);
  endtask

  task automatic read_byte(input logic [7:0] a);
    wr(0, a); wr(2, 8'h05); rdr(2); rdr(1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    bus_we = 0; bus_re = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R1";
    for (int s = 0; s < 4; s++) rdr(2'(s));
    wr(0, 8'hA5); wr(1, 8'h3C); rdr(0); rdr(1);
    wr_rd(3, 8'h12); rdr(3);

    cur_req = "R10";
    step(0, 0, 0, 8'h00, 0); step(0, 0, 1, 8'h00, 0); step(0, 0, 2, 8'h00, 0);

    cur_req = "R3";
    wr(0, 8'h02); wr(1, 8'h77); wr(2, 8'h00);
    unlock_start(); poll(3);
    wr(2, 8'h04); unlock_start(); poll(W + 2);
    read_byte(8'h02);

    cur_req = "R2";
    wr(0, 8'h03); wr(1, 8'h99); wr(2, 8'h04);
    wr(2, 8'h06); poll(2);
    wr(3, 8'h55); wr(2, 8'h06); poll(2);
    wr(3, 8'h55); wr(1, 8'h99); wr(3, 8'hAA); wr(2, 8'h06); poll(2);
    wr(3, 8'hAA); wr(3, 8'h55); wr(2, 8'h06); poll(2);
    wr(3, 8'h55); wr(3, 8'h55); wr(3, 8'hAA); wr(2, 8'h06); poll(2);
    read_byte(8'h03);

    cur_req = "R4";
    wr(0, 8'h10); wr(1, 8'h5A); wr(2, 8'h04);
    unlock_start();
    wr(0, 8'h11); wr(1, 8'hEE);
    poll(W + 2);
    read_byte(8'h10); read_byte(8'h11);

    cur_req = "R5";
    wr(0, 8'h02); wr_rd(2, 8'h05); rdr(2); rdr(2); rdr(1);
    wr(2, 8'h05); wr(2, 8'h05); rdr(2);

    cur_req = "R6";
    wr(2, 8'h1C); rdr(2); wr(2, 8'h04); rdr(2);

    cur_req = "R7";
    wr(2, 8'h04); step(0, 1, 2, 8'h00, 1); rdr(2);
    wr(0, 8'h20); wr(1, 8'hC3); unlock_start(); poll(3);
    step(0, 1, 2, 8'h00, 1); poll(W + 2); read_byte(8'h20);
    wr(2, 8'h04); rdr(2);

    cur_req = "R8";
    wr(0, 8'h21); wr(1, 8'h44); unlock_start();
    for (int i = 0; i < W - 1; i++) rdr(2);
    wr(2, 8'h04); rdr(2); read_byte(8'h21);
    wr(0, 8'h22); wr(1, 8'h66); unlock_start();
    for (int i = 0; i < W - 1; i++) rdr(2);
    step(0, 1, 2, 8'h00, 1); rdr(2); read_byte(8'h22);
    wr(2, 8'h04);

    cur_req = "R9";
    wr(0, 8'hC5); wr(1, 8'hB7); unlock_start(); poll(W + 2);
    read_byte(8'h05); read_byte(8'h45); read_byte(8'h85);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule